// File: doc/BRIEF.md
# Serial Register Access Decoder

This block is the serial slave front end of a bank of 32 registers, each 24 bits wide. A master lowers chip select and sends a one-byte command on the serial data input. The block decodes that byte as a read or a write of one register. On a read it takes a copy of the addressed register and shifts that copy out. On a write it collects 24 data bits in a staging buffer. The register changes only once the last of those bits has arrived, so a transfer that is cut short leaves the register as it was.

The serial clock, chip select and data input are synchronised into the system clock domain. All decoding, shifting and committing runs on the system clock. Internal logic has its own port on the bank. It can update any register with a single-cycle write strobe and read any register through a registered look-up port.

Top module: `serreg_access`

## Requirements
- R1: A command byte carries the direction in bit 6 (1 = write, 0 = read) and the register address in bits 5..1. Bits 7 and 0 must both be 0 for the byte to be accepted.
- R2: A read presents the register value on `miso_o` most significant bit first, one bit per serial clock. Data changes after a falling serial-clock edge and is sampled by the master on the rising edge. Each serial-clock phase lasts at least 6 system clocks.
- R3: A write applies its 24 data bits, most significant first, to the addressed register only after the 24th data bit has been clocked in.
- R4: A command byte with bit 7 or bit 0 set is ignored, and the next byte in the same frame is decoded as a fresh command.
- R5: Raising `cs_n_i` before a transfer ends aborts it. A partial write is dropped, and the next frame starts again with a command byte.
- R6: The value shifted out by a read is the register content captured just after the command byte. Internal updates to that register during the shift-out do not change the bits sent.
- R7: Addresses whose bit is set in the `RO_MASK` parameter (by default addresses 24 to 31) ignore serial writes.
- R8: When an internal update and a serial commit fall in the same cycle, the internal update is applied first. The serial commit is applied in the first later cycle with no internal update, so on the same address the serial value is the one that remains.
- R9: `look_data_o` shows the register at `look_addr_i` two clock edges after the address is applied. It reflects every update applied before the read edge.
- R10: `miso_o` is 0 after reset, while the block is deselected, and whenever no read data phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the master |
| cs_n_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial read data to the master |
| upd_we_i | input | 1 | Internal update strobe |
| upd_addr_i | input | 5 | Internal update address |
| upd_data_i | input | 24 | Internal update data |
| look_addr_i | input | 5 | Internal look-up address |
| look_data_o | output | 24 | Internal look-up data (registered) |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a serial commit and an internal update, which share one write port on the bank. The bench holds the internal update strobe high across the rising edge of the 24th data bit, once on a different address and once on the same address. It then judges from the look-up port that both values arrive, and that on the same address the serial value wins. The second pair is a read in progress and an internal update to the register being sent. Here the bench writes the register midway through the shift-out and expects the old value on the serial line and the new value on the look-up port.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_LD0,
    ST_LD1,
    ST_RD,
    ST_WR
  } seq_st_t;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              upd_we_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic              cm_we_i,
  input  logic [ADDR_W-1:0] cm_addr_i,
  input  logic [DATA_W-1:0] cm_data_i,
  input  logic [ADDR_W-1:0] sp_addr_i,
  output logic [DATA_W-1:0] sp_data_o,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic [DATA_W-1:0] lk_data_o
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NREG];
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  // internal update owns the single write port when both want it
  always_comb begin
    we    = upd_we_i | cm_we_i;
    waddr = upd_we_i ? upd_addr_i : cm_addr_i;
    wdata = upd_we_i ? upd_data_i : cm_data_i;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    sp_data_o <= mem[sp_addr_i];
    lk_data_o <= mem[lk_addr_i];
  end
endmodule

// File: rtl/serreg_seq.sv
module serreg_seq
  import serreg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 24,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              desel_s,
  input  logic              mosi_s,
  input  logic              hold_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              miso_o,
  output logic              cm_we_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [DATA_W-1:0] cm_data_o
);
  localparam int CMD_W = ADDR_W + 3;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  seq_st_t           st;
  logic              sclk_q;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-2:0]  cmd_sr;
  logic [CMD_W-1:0]  cmd_nxt;
  logic [DATA_W-2:0] wr_buf;
  logic [DATA_W-1:0] wr_nxt;
  logic [DATA_W-1:0] rd_buf;
  logic [ADDR_W-1:0] addr_q;
  logic              commit_q;

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign cmd_nxt = {cmd_sr, mosi_s};
  assign wr_nxt  = {wr_buf, mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sclk_q    <= 1'b0;
      cnt       <= '0;
      cmd_sr    <= '0;
      wr_buf    <= '0;
      rd_buf    <= '0;
      addr_q    <= '0;
      commit_q  <= 1'b0;
      cm_addr_o <= '0;
      cm_data_o <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (commit_q && !hold_i) commit_q <= 1'b0;
      if (desel_s) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        rd_buf <= '0;
        wr_buf <= '0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            st  <= ST_CMD;
            cnt <= '0;
          end
          ST_CMD: if (rise) begin
            cmd_sr <= cmd_nxt[CMD_W-2:0];
            if (cnt == CMD_LAST) begin
              cnt <= '0;
              if (!cmd_nxt[CMD_W-1] && !cmd_nxt[0]) begin
                addr_q <= cmd_nxt[ADDR_W:1];
                st     <= cmd_nxt[CMD_W-2] ? ST_WR : ST_LD0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_LD0: st <= ST_LD1;
          ST_LD1: begin
            rd_buf <= rd_data_i;
            cnt    <= '0;
            st     <= ST_RD;
          end
          ST_RD: begin
            if (rise) begin
              if (cnt == DAT_LAST) begin
                cnt    <= '0;
                rd_buf <= '0;
                st     <= ST_CMD;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (fall && cnt != '0) begin
              rd_buf <= {rd_buf[DATA_W-2:0], 1'b0};
            end
          end
          ST_WR: if (rise) begin
            wr_buf <= wr_nxt[DATA_W-2:0];
            if (cnt == DAT_LAST) begin
              cnt <= '0;
              st  <= ST_CMD;
              if (!RO_MASK[addr_q]) begin
                commit_q  <= 1'b1;
                cm_addr_o <= addr_q;
                cm_data_o <= wr_nxt;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign miso_o    = rd_buf[DATA_W-1];
  assign cm_we_o   = commit_q;

  AST_ABORT_RESETS: assert property (@(posedge clk) disable iff (rst)
    desel_s |=> (st == ST_IDLE && cnt == '0 && rd_buf == '0)); // R5
  AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_q) |-> ($past(st) == ST_WR && $past(cnt) == DAT_LAST)); // R3
  AST_RO_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> !RO_MASK[cm_addr_o]); // R7
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_CMD) |-> !miso_o); // R10
  AST_SNAPSHOT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD && !rise && !fall && !desel_s) |=> $stable(rd_buf)); // R6
  AST_COMMIT_WAITS: assert property (@(posedge clk) disable iff (rst)
    (commit_q && hold_i) |=> commit_q); // R8
endmodule

// File: rtl/serreg_access.sv
module serreg_access #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = 32'hFF00_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              upd_we_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic [DATA_W-1:0] look_data_o
);
  logic [2:0]        pins_s;
  logic              cm_we;
  logic [ADDR_W-1:0] cm_addr;
  logic [DATA_W-1:0] cm_data;
  logic [ADDR_W-1:0] sp_addr;
  logic [DATA_W-1:0] sp_data;

  serreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sclk_i, cs_n_i, mosi_i}),
    .q_o (pins_s)
  );

  serreg_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s[2]),
    .desel_s   (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .hold_i    (upd_we_i),
    .rd_addr_o (sp_addr),
    .rd_data_i (sp_data),
    .miso_o    (miso_o),
    .cm_we_o   (cm_we),
    .cm_addr_o (cm_addr),
    .cm_data_o (cm_data)
  );

  serreg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .upd_we_i   (upd_we_i),
    .upd_addr_i (upd_addr_i),
    .upd_data_i (upd_data_i),
    .cm_we_i    (cm_we),
    .cm_addr_i  (cm_addr),
    .cm_data_i  (cm_data),
    .sp_addr_i  (sp_addr),
    .sp_data_o  (sp_data),
    .lk_addr_i  (look_addr_i),
    .lk_data_o  (look_data_o)
  );
endmodule

// File: tb/sim_serreg_access.sv
module sim_serreg_access;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic        upd_we = 1'b0;
  logic [4:0]  upd_addr = '0, look_addr = '0;
  logic [23:0] upd_data = '0;
  logic [23:0] look_data;

  int n_chk  = 0;
  int n_fail = 0;
  int idle_cnt = 0;
  logic [23:0] ref_mem [32];

  serreg_access u0 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .upd_we_i(upd_we), .upd_addr_i(upd_addr),
    .upd_data_i(upd_data), .look_addr_i(look_addr), .look_data_o(look_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of the serial output while deselected
  always @(negedge clk) begin
    if (rst || !cs_n) idle_cnt <= 0;
    else idle_cnt <= idle_cnt + 1;
    if (!rst && cs_n && idle_cnt > 4) chk(miso == 1'b0, "R10 idle miso", 24'(miso), 24'h0);
  end

  task automatic int_wr(input logic [4:0] a, input logic [23:0] d);
    @(negedge clk);
    upd_we = 1'b1; upd_addr = a; upd_data = d;
    @(negedge clk);
    upd_we = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic peek(input logic [4:0] a, input string req);
    @(negedge clk);
    look_addr = a;
    @(negedge clk);
    @(negedge clk);
    chk(look_data == ref_mem[a], req, look_data, ref_mem[a]);
  endtask

  task automatic spi_bit(input logic b, output logic smp);
    mosi = b;
    repeat (HALF) @(negedge clk);
    smp  = miso;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame_on();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_off();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) spi_bit(b[i], s);
  endtask

  // mode 1: single internal write before bit hk; mode 2: strobe held across bit hk
  task automatic xfer24(input logic [23:0] din, output logic [23:0] dout,
                        input int hk, input int mode, input logic [4:0] ha, input logic [23:0] hd);
    logic s;
    dout = '0;
    for (int i = 0; i < 24; i++) begin
      if (i == hk && mode == 1) int_wr(ha, hd);
      if (i == hk && mode == 2) begin
        upd_we = 1'b1; upd_addr = ha; upd_data = hd;
      end
      spi_bit(din[23-i], s);
      dout = {dout[22:0], s};
      if (i == hk && mode == 2) begin
        repeat (4) @(negedge clk);
        upd_we = 1'b0;
        ref_mem[ha] = hd;
      end
    end
  endtask

  function automatic logic [7:0] cmd(input logic wr, input logic [4:0] a);
    return {1'b0, wr, a, 1'b0};
  endfunction

  task automatic serial_read(input logic [4:0] a, input string req);
    logic [23:0] got, exp;
    exp = ref_mem[a];
    frame_on();
    send_byte(cmd(1'b0, a));
    xfer24('0, got, -1, 0, '0, '0);
    frame_off();
    chk(got == exp, req, got, exp);
  endtask

  task automatic serial_write(input logic [4:0] a, input logic [23:0] d);
    logic [23:0] dummy;
    frame_on();
    send_byte(cmd(1'b1, a));
    xfer24(d, dummy, -1, 0, '0, '0);
    frame_off();
    if (a < 5'd24) ref_mem[a] = d;
  endtask

  initial begin
    logic [23:0] got, exp, dummy;
    logic s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(miso == 1'b0, "R10 reset miso", 24'(miso), 24'h0);

    for (int a = 0; a < 32; a++) int_wr(5'(a), 24'hA50000 ^ (24'(a) * 24'h010203));
    peek(5'd7, "R9 look-up after update");
    peek(5'd30, "R9 look-up high address");

    // R1 R2: plain reads, MSB first
    serial_read(5'd3, "R2 read addr 3");
    serial_read(5'd31, "R1 read addr 31");

    // R1 R3: full writes then read back both ways
    serial_write(5'd5, 24'h800001);
    peek(5'd5, "R3 write committed");
    serial_read(5'd5, "R2 read back MSB/LSB pattern");
    serial_write(5'd12, 24'h5A3C96);
    serial_read(5'd12, "R1 write then read addr 12");

    // R5: partial write aborted by chip select
    frame_on();
    send_byte(cmd(1'b1, 5'd4));
    for (int i = 0; i < 12; i++) spi_bit(1'b1, s);
    frame_off();
    peek(5'd4, "R5 partial write dropped");
    serial_read(5'd4, "R5 next frame starts with command");

    // R4: bad framing (bit 0 set on a write) leaves register untouched
    frame_on();
    send_byte(8'h45);
    frame_off();
    peek(5'd2, "R4 bad write command ignored");

    // R4: bad byte (bit 7 set) then valid read in same frame
    exp = ref_mem[5'd9];
    frame_on();
    send_byte(8'h92);
    send_byte(cmd(1'b0, 5'd9));
    xfer24('0, got, -1, 0, '0, '0);
    frame_off();
    chk(got == exp, "R4 next byte decoded as command", got, exp);

    // R7: read-only address
    serial_write(5'd26, 24'h123456);
    peek(5'd26, "R7 read-only unchanged");
    serial_write(5'd23, 24'h654321);
    peek(5'd23, "R7 writable edge address");

    // R6: internal update mid shift-out
    exp = ref_mem[5'd8];
    frame_on();
    send_byte(cmd(1'b0, 5'd8));
    xfer24('0, got, 6, 1, 5'd8, 24'h0F0F0F);
    frame_off();
    chk(got == exp, "R6 snapshot kept", got, exp);
    peek(5'd8, "R6 update landed");

    // R8: collision, different addresses
    frame_on();
    send_byte(cmd(1'b1, 5'd10));
    xfer24(24'hC0FFEE, dummy, 23, 2, 5'd11, 24'h111111);
    frame_off();
    ref_mem[5'd10] = 24'hC0FFEE;
    peek(5'd10, "R8 deferred serial commit");
    peek(5'd11, "R8 internal update kept");

    // R8: collision, same address, serial value remains
    frame_on();
    send_byte(cmd(1'b1, 5'd13));
    xfer24(24'hABCDEF, dummy, 23, 2, 5'd13, 24'h222222);
    frame_off();
    ref_mem[5'd13] = 24'hABCDEF;
    peek(5'd13, "R8 serial wins same address");

    // R3: write then abort mid-read keeps data
    frame_on();
    send_byte(cmd(1'b0, 5'd12));
    for (int i = 0; i < 5; i++) spi_bit(1'b0, s);
    frame_off();
    chk(miso == 1'b0, "R5 miso low after abort", 24'(miso), 24'h0);
    serial_read(5'd12, "R3 value intact after aborted read");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 24'h1, 24'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule